// File: doc/BRIEF.md
# Programmable Line Delay Controller

This block sequences the control strobes of a dual-port line buffer (a RAM with free-running, active-low write and read address counters, each with its own enable and synchronous counter reset, and no status flags) so that the buffer's read data reproduces its write data a programmable number of samples later. Both sides of the buffer run from the one clock that also drives this controller. The delay is any value from 1 up to the buffer depth of 2**ADDR_W words.

A start pulse captures a delay length and one of three counter-manipulation methods. In the periodic method both counters are cleared together every n cycles. In the offset method the write counter is cleared once and the read counter n cycles later. In the held method both counters are cleared together and reading is kept disabled for n cycles. A valid flag tells the consumer when the buffer output first carries the delayed copy of the first sample written after the start.

Cycle numbering used below: the clock edge that samples `start` high is followed by cycle 0; cycle k is the k-th period after that. The strobe values of cycle k are sampled by the buffer at the edge that ends cycle k.

Top module: `line_delay_ctrl`

## Requirements
- R1: After reset, and until the first start pulse, all four strobes (`buf_we_n`, `buf_wclr_n`, `buf_re_n`, `buf_rclr_n`) are high (inactive) and `delay_ok` is low.
- R2: From cycle 0 of the first run onward, `buf_we_n` is low in every cycle.
- R3: `dly_len` is captured only on the start pulse; code 0 means 2**ADDR_W and any other code k means k; changes to `dly_len` or `dly_mode` between start pulses have no effect on the strobes.
- R4: `dly_mode` encoding: 0 selects periodic, 1 selects offset, 2 selects held, and 3 behaves as periodic.
- R5: Periodic: `buf_wclr_n` and `buf_rclr_n` are both low in cycle k exactly when k mod n is 0, and `buf_re_n` is low in every cycle of the run.
- R6: Offset: `buf_wclr_n` is low only in cycle 0, `buf_rclr_n` is low only in cycle n, and `buf_re_n` is low in every cycle of the run.
- R7: Held: both clear strobes are low only in cycle 0; `buf_re_n` is high in cycles 0 to n-1 and low from cycle n onward.
- R8: `delay_ok` is low in cycles 0 to n and high from cycle n+1 until the next start pulse.
- R9: With a buffer that reads the old word when the same address is written and read at one edge, the buffer's read data in every cycle k >= n+1 equals the write data it sampled n edges earlier.
- R10: A start pulse during a run (before or after `delay_ok`) restarts the sequence at cycle 0 with the newly captured settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by controller and both buffer sides |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that captures settings and begins a run |
| dly_len | input | ADDR_W | Delay length; 0 encodes 2**ADDR_W |
| dly_mode | input | 2 | Method select (see R4) |
| buf_we_n | output | 1 | Buffer write enable, active low |
| buf_wclr_n | output | 1 | Buffer write counter clear, active low |
| buf_re_n | output | 1 | Buffer read enable, active low |
| buf_rclr_n | output | 1 | Buffer read counter clear, active low |
| delay_ok | output | 1 | High when buffer read data is the delayed stream |

## Verification
The embedded properties watch, on every cycle, that the write enable never lets go once asserted, that read enable is never released without a new start, that the two clears move together in periodic mode and follow the phase counter, that the offset clears never coincide and the read clear lasts one cycle, and that the counters stay inside their limits. Only the bench's scenarios can show the end-to-end result: that the data leaving a behavioural buffer is exactly the input n samples back for each method at lengths 1, random values and the full depth, that `delay_ok` rises in precisely cycle n+1, and that settings changed mid-run are ignored while a restart takes effect at once.

// File: rtl/lnd_pkg.sv
`timescale 1ns/1ps
package lnd_pkg;

   typedef enum logic [1:0] {
      LND_PERIODIC = 2'd0,
      LND_OFFSET   = 2'd1,
      LND_HOLD     = 2'd2,
      LND_SPARE    = 2'd3
   } lnd_mode_e;

   // code 3 folds onto the periodic method
   function automatic lnd_mode_e lnd_decode(input logic [1:0] sel);
      case (sel)
         2'd1:    return LND_OFFSET;
         2'd2:    return LND_HOLD;
         default: return LND_PERIODIC;
      endcase
   endfunction

endpackage

// File: rtl/lnd_cfg_latch.sv
`timescale 1ns/1ps
module lnd_cfg_latch
   import lnd_pkg::*;
#(
   parameter int ADDR_W = 13,
   localparam int CW = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] len_in,
   input  logic [1:0]        sel_in,
   output logic [CW-1:0]     limit_q,
   output logic [CW-1:0]     limit_nxt,
   output lnd_mode_e         mode_q,
   output lnd_mode_e         mode_nxt,
   output logic              run_q
);

   localparam logic [CW-1:0] FULL = {1'b1, {ADDR_W{1'b0}}};

   always_comb begin
      limit_nxt = limit_q;
      mode_nxt  = mode_q;
      if (start) begin
         limit_nxt = (len_in == '0) ? FULL : {1'b0, len_in};
         mode_nxt  = lnd_decode(sel_in);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit_q <= FULL;
         mode_q  <= LND_PERIODIC;
         run_q   <= 1'b0;
      end else begin
         limit_q <= limit_nxt;
         mode_q  <= mode_nxt;
         if (start) run_q <= 1'b1;
      end
   end

   // R3
   limit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (limit_q != '0) && (limit_q <= FULL));

endmodule

// File: rtl/lnd_counter.sv
`timescale 1ns/1ps
module lnd_counter #(
   parameter int CW   = 14,
   parameter bit WRAP = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          run,
   input  logic [CW-1:0] limit,
   output logic [CW-1:0] cnt_q,
   output logic [CW-1:0] cnt_nxt
);

   localparam logic [CW-1:0] ONE = CW'(1);

   generate
      if (WRAP) begin : g_wrap
         always_comb begin
            if (start)                    cnt_nxt = '0;
            else if (!run)                cnt_nxt = cnt_q;
            else if (cnt_q >= limit - ONE) cnt_nxt = '0;
            else                          cnt_nxt = cnt_q + ONE;
         end
         // R5
         wrap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q < limit);
      end else begin : g_sat
         always_comb begin
            if (start)               cnt_nxt = '0;
            else if (!run)           cnt_nxt = cnt_q;
            else if (cnt_q >= limit) cnt_nxt = limit;
            else                     cnt_nxt = cnt_q + ONE;
         end
         // R8
         sat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= limit);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end

endmodule

// File: rtl/lnd_strobe_gen.sv
`timescale 1ns/1ps
module lnd_strobe_gen
   import lnd_pkg::*;
#(
   parameter int CW = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          run_q,
   input  lnd_mode_e     mode_nxt,
   input  logic [CW-1:0] limit_q,
   input  logic [CW-1:0] limit_nxt,
   input  logic [CW-1:0] el_q,
   input  logic [CW-1:0] el_nxt,
   input  logic [CW-1:0] ph_nxt,
   output logic          we_n,
   output logic          wclr_n,
   output logic          re_n,
   output logic          rclr_n,
   output logic          ok
);

   localparam logic [CW-1:0] ONE = CW'(1);

   logic run_nxt, w_hit, r_hit, r_act;

   always_comb begin
      run_nxt = run_q | start;
      case (mode_nxt)
         LND_OFFSET: begin
            w_hit = start;
            r_hit = !start && run_q && (el_q == limit_q - ONE);
            r_act = 1'b1;
         end
         LND_HOLD: begin
            w_hit = start;
            r_hit = start;
            r_act = (el_nxt >= limit_nxt);
         end
         default: begin
            w_hit = (ph_nxt == '0);
            r_hit = (ph_nxt == '0);
            r_act = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_n   <= 1'b1;
         wclr_n <= 1'b1;
         re_n   <= 1'b1;
         rclr_n <= 1'b1;
         ok     <= 1'b0;
      end else begin
         we_n   <= !run_nxt;
         wclr_n <= !(run_nxt && w_hit);
         rclr_n <= !(run_nxt && r_hit);
         re_n   <= !(run_nxt && r_act);
         ok     <= !start && run_q && (el_q == limit_q);
      end
   end

   // R2
   we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |=> !we_n);

   // R7
   re_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!re_n && !start) |=> !re_n);

   // R8
   ok_reading_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ok |-> (!re_n && !we_n));

endmodule

// File: rtl/line_delay_ctrl.sv
`timescale 1ns/1ps
module line_delay_ctrl
   import lnd_pkg::*;
#(
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] dly_len,
   input  logic [1:0]        dly_mode,
   output logic              buf_we_n,
   output logic              buf_wclr_n,
   output logic              buf_re_n,
   output logic              buf_rclr_n,
   output logic              delay_ok
);

   localparam int CW = ADDR_W + 1;

   generate
      if (ADDR_W < 1 || ADDR_W > 24) begin : g_bad_width
         $error("line_delay_ctrl: ADDR_W must lie in 1..24");
      end
   endgenerate

   logic [CW-1:0] limit_q, limit_nxt;
   logic [CW-1:0] el_q, el_nxt, ph_q, ph_nxt;
   lnd_mode_e     mode_q, mode_nxt;
   logic          run_q;

   lnd_cfg_latch #(.ADDR_W(ADDR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .start(start),
      .len_in(dly_len), .sel_in(dly_mode),
      .limit_q(limit_q), .limit_nxt(limit_nxt),
      .mode_q(mode_q), .mode_nxt(mode_nxt), .run_q(run_q)
   );

   lnd_counter #(.CW(CW), .WRAP(1'b0)) u_elapsed (
      .clk(clk), .rst_n(rst_n), .start(start), .run(run_q),
      .limit(limit_q), .cnt_q(el_q), .cnt_nxt(el_nxt)
   );

   lnd_counter #(.CW(CW), .WRAP(1'b1)) u_phase (
      .clk(clk), .rst_n(rst_n), .start(start), .run(run_q),
      .limit(limit_q), .cnt_q(ph_q), .cnt_nxt(ph_nxt)
   );

   lnd_strobe_gen #(.CW(CW)) u_strobe (
      .clk(clk), .rst_n(rst_n), .start(start), .run_q(run_q),
      .mode_nxt(mode_nxt), .limit_q(limit_q), .limit_nxt(limit_nxt),
      .el_q(el_q), .el_nxt(el_nxt), .ph_nxt(ph_nxt),
      .we_n(buf_we_n), .wclr_n(buf_wclr_n), .re_n(buf_re_n),
      .rclr_n(buf_rclr_n), .ok(delay_ok)
   );

   // R5
   per_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == LND_PERIODIC) |-> (buf_wclr_n == buf_rclr_n));

   // R5
   per_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == LND_PERIODIC && run_q) |-> ((!buf_wclr_n) == (ph_q == '0)));

   // R6
   ofs_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == LND_OFFSET) |-> (buf_wclr_n || buf_rclr_n));

   // R6
   ofs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == LND_OFFSET && !buf_rclr_n && !start) |=> buf_rclr_n);

endmodule

// File: tb/sim_line_delay_ctrl.sv
`timescale 1ns/1ps
module sim_line_buf #(
   parameter int AW = 10,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we_n,
   input  logic          wclr_n,
   input  logic          re_n,
   input  logic          rclr_n,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);
   logic [DW-1:0] mem [1<<AW];
   logic [AW-1:0] wa = '0, ra = '0;
   logic [DW-1:0] qr = '0;
   logic          oe = 1'b0;
   logic [AW-1:0] wsel, rsel;

   always_comb begin
      wsel = wclr_n ? wa : '0;
      rsel = rclr_n ? ra : '0;
   end

   always_ff @(posedge clk) begin
      if (!we_n) begin
         mem[wsel] <= d;
         wa <= wsel + 1'b1;
      end else if (!wclr_n) wa <= '0;
      if (!re_n) begin
         qr <= mem[rsel];
         ra <= rsel + 1'b1;
      end else if (!rclr_n) ra <= '0;
      oe <= !re_n;
   end

   assign q = oe ? qr : 'z;
endmodule

module sim_line_delay_ctrl;
   localparam int AW    = 10;
   localparam int DEPTH = 1 << AW;
   localparam int HD    = 4096;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [AW-1:0] dly_len = '0;
   logic [1:0] dly_mode = '0;
   logic buf_we_n, buf_wclr_n, buf_re_n, buf_rclr_n, delay_ok;
   logic [7:0] din = '0;
   logic [7:0] q;

   always #2.5 clk = ~clk;

   line_delay_ctrl #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .dly_len(dly_len),
      .dly_mode(dly_mode), .buf_we_n(buf_we_n), .buf_wclr_n(buf_wclr_n),
      .buf_re_n(buf_re_n), .buf_rclr_n(buf_rclr_n), .delay_ok(delay_ok)
   );

   sim_line_buf #(.AW(AW), .DW(8)) u_buf (
      .clk(clk), .we_n(buf_we_n), .wclr_n(buf_wclr_n), .re_n(buf_re_n),
      .rclr_n(buf_rclr_n), .d(din), .q(q)
   );

   int ec = 0;
   always @(posedge clk) ec <= ec + 1;

   logic [7:0] hist [HD];
   int n_checks = 0, n_fail = 0;
   bit started = 0, done = 0;
   int s_edge = 0, cur_n = 1, cur_m = 0;

   function automatic int mode_of(input int sel);
      return (sel == 1) ? 1 : (sel == 2) ? 2 : 0;
   endfunction
   function automatic bit exp_wclr(input int m, input int n, input int k);
      return (m == 0) ? (k % n == 0) : (k == 0);
   endfunction
   function automatic bit exp_rclr(input int m, input int n, input int k);
      if (m == 1) return k == n;
      if (m == 2) return k == 0;
      return k % n == 0;
   endfunction
   function automatic bit exp_re(input int m, input int n, input int k);
      return (m == 2) ? (k >= n) : 1'b1;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at edge %0d: actual %0h expected %0h", tag, ec, act, exp);
      end
   endtask

   task automatic do_checks();
      if (!started) begin
         // R1 idle strobes and flag
         chk({buf_we_n, buf_wclr_n, buf_re_n, buf_rclr_n, delay_ok} == 5'b11110,
             "R1 idle outputs",
             {buf_we_n, buf_wclr_n, buf_re_n, buf_rclr_n, delay_ok}, 5'b11110);
      end else begin
         int k = ec - s_edge;
         chk(buf_we_n == 1'b0, "R2 write enable", buf_we_n, 0);
         // R5 R6 R7 (method strobes), R3 R4 via captured settings
         chk(buf_wclr_n == !exp_wclr(cur_m, cur_n, k), "R5/R6/R7 wclr R4",
             buf_wclr_n, !exp_wclr(cur_m, cur_n, k));
         chk(buf_rclr_n == !exp_rclr(cur_m, cur_n, k), "R5/R6/R7 rclr R3",
             buf_rclr_n, !exp_rclr(cur_m, cur_n, k));
         chk(buf_re_n == !exp_re(cur_m, cur_n, k), "R5/R6/R7 re",
             buf_re_n, !exp_re(cur_m, cur_n, k));
         // R8 R10
         chk(delay_ok == (k >= cur_n + 1), "R8 delay_ok timing", delay_ok, k >= cur_n + 1);
         if (k >= cur_n + 1) begin
            logic [7:0] e = hist[(ec - cur_n) % HD];
            // R9
            chk(q === e, "R9 delayed data", q, e);
         end
      end
   endtask

   task automatic tick(input bit st, input int len, input int sel);
      @(negedge clk);
      do_checks();
      start = st;
      if (st) begin
         dly_len  = AW'(len);
         dly_mode = 2'(sel);
         cur_m    = mode_of(sel);
         cur_n    = (len == 0) ? DEPTH : len;
         s_edge   = ec + 1;
         started  = 1;
      end else begin
         // R3: mid-run changes must be ignored
         dly_len  = AW'($urandom);
         dly_mode = 2'($urandom);
      end
      din = 8'($urandom);
      hist[(ec + 1) % HD] = din;
   endtask

   task automatic run(input int sel, input int len, input int cycles);
      tick(1'b1, len, sel);
      for (int i = 0; i < cycles; i++) tick(1'b0, 0, 0);
   endtask

   function automatic int run_len(input int len);
      int n = (len == 0) ? DEPTH : len;
      return n + ((n < 300) ? n : 300) + 20;
   endfunction

   initial begin
      void'($urandom(32'd5150));
      for (int i = 0; i < HD; i++) hist[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) tick(1'b0, 0, 0);
      // directed corners: length 1, full depth, spare code 3, restart
      run(0, 1, run_len(1));
      run(1, 1, run_len(1));
      run(2, 1, run_len(1));
      run(0, 0, run_len(0));
      run(1, 0, run_len(0));
      run(2, 0, run_len(0));
      run(3, 5, run_len(5));
      run(2, 200, 50);          // R10 restart before valid
      run(1, 37, 60);           // R10 restart after valid
      for (int r = 0; r < 20; r++) begin
         int sel = int'($urandom % 4);
         int len = 1 + int'($urandom % 300);
         run(sel, len, run_len(len));
      end
      tick(1'b0, 0, 0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule